// File: doc/BRIEF.md
# Per-Core Level Interrupt Aggregator

This block gathers a parameterized set of level-sensitive peripheral interrupt lines (32, 64 or 128 of them) and produces one interrupt request per CPU core, for one or two cores. Every line is brought into the local clock domain by a two-flop synchronizer. Each core then owns a private bank of 32-bit mask words. A line reaches a core only when that core's mask bit for the line is set, so software can steer any peripheral to either core, or to both.

Software sees each core's bank through a 32-byte window on a simple valid/write register bus. Each 32-line group has one status word and one enable word. A status word is a live view: the synchronized line levels ANDed with the core's enable bits. Nothing is latched. There is no priority encoding and there are no set/clear alias registers. Software changes enables by writing the whole word, and it finds pending lines by scanning every status word.

Top module: `irq_aggr`

## Requirements
- R1: After reset, every enable word reads zero, every cpuIrq bit is low and busRdata is zero.
- R2: A write to an enable word stores all 32 bits of busWdata. A later read of that word returns the same value.
- R3: A status word reads as the synchronized line levels ANDed with that core's enable word for the group. It follows the inputs without latching, so a line that drops clears its status bit.
- R4: Writes to status words are ignored. No enable word changes and no cpuIrq output changes.
- R5: Core c's window starts at byte address c*0x20, and the word index is busAddr[4:2]. With G = lines/32 groups, word k < G is the status word of group G-1-k, and word G+k is the enable word of group G-1-k. The highest-numbered group therefore sits at the lowest offset. busAddr[1:0] are ignored.
- R6: cpuIrq[c] is the registered OR of all of core c's status bits. A line change appears on cpuIrq on the third rising edge after it is sampled (two synchronizer stages plus the output register). An enable write appears on cpuIrq one edge after the write edge.
- R7: The two cores' banks are independent. An enable or line routed to one core never affects the other core's status words or cpuIrq.
- R8: A read of an unmapped offset (word index 2G or above, or a core index beyond the number of cores) returns zero.
- R9: Read data is registered. It appears on busRdata after the edge that accepts the read, and it is held unchanged through idle cycles and writes until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| irqIn | input | NUM_LINES | Level-sensitive peripheral interrupt lines |
| busValid | input | 1 | Register access strobe, one cycle per access |
| busWrite | input | 1 | 1 = write, 0 = read |
| busAddr | input | ADDR_W | Byte address of the access |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Registered read data |
| cpuIrq | output | NUM_CORES | Interrupt request, one per core |

## Verification
Three latencies are due. A line change reaches cpuIrq three edges after the first sampling edge. An enable write reaches cpuIrq one edge after the write edge. Read data is due on the edge that accepts the read. The bench drives every input at a falling edge and counts rising edges from there. It checks cpuIrq both one cycle before and exactly at the due edge, so a wrong pipeline depth is caught in either direction. Reads push their expected word into a queue. A monitor pops that word at the falling edge after the accepting rising edge, and status reads are issued only once the synchronizer has settled.

// File: rtl/irq_aggr_pkg.sv
package irq_aggr_pkg;
  localparam int MaxCores  = 2;
  localparam int MaxGroups = 4;
  localparam int MaxSlots  = MaxCores * MaxGroups;

  typedef struct packed {
    logic [MaxSlots-1:0] enWrite;   // one strobe per (core, group) enable word
    logic                rdStrobe;  // a read is accepted this cycle
    logic                rdMapped;  // the read hits a real register
    logic                rdEnable;  // 1 = enable word, 0 = status word
    logic                rdCore;
    logic [1:0]          rdGroup;
  } aggrStrobe_t;
endpackage

// File: rtl/irq_aggr_ctrl.sv
module irq_aggr_ctrl
  import irq_aggr_pkg::*;
#(
  parameter int NUM_CORES = 2,
  parameter int GROUPS    = 2,
  parameter int ADDR_W    = 6
) (
  input  logic              busValid,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  output aggrStrobe_t       strobe
);
  int   coreIdx;
  int   word;
  int   grp;
  logic coreOk;
  logic isStat;
  logic isEn;
  logic unusedLow;

  assign unusedLow = ^busAddr[1:0];

  always_comb begin
    coreIdx = int'(busAddr[ADDR_W-1:5]);
    word    = int'(busAddr[4:2]);
    coreOk  = coreIdx < NUM_CORES;
    isStat  = word < GROUPS;
    isEn    = !isStat && (word < 2 * GROUPS);
    grp     = isStat ? (GROUPS - 1 - word) : (2 * GROUPS - 1 - word);

    strobe          = '0;
    strobe.rdStrobe = busValid && !busWrite;
    strobe.rdMapped = coreOk && (isStat || isEn);
    strobe.rdEnable = isEn;
    strobe.rdCore   = busAddr[5];
    strobe.rdGroup  = 2'(grp);
    for (int s = 0; s < MaxSlots; s++) begin
      strobe.enWrite[s] = busValid && busWrite && coreOk && isEn &&
                          (s == coreIdx * MaxGroups + grp);
    end
  end
endmodule

// File: rtl/irq_aggr_datapath.sv
module irq_aggr_datapath
  import irq_aggr_pkg::*;
#(
  parameter int NUM_LINES = 64,
  parameter int NUM_CORES = 2,
  parameter int GROUPS    = NUM_LINES / 32
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_LINES-1:0] irqIn,
  input  logic [31:0]          busWdata,
  input  aggrStrobe_t          strobe,
  output logic [31:0]          busRdata,
  output logic [NUM_CORES-1:0] cpuIrq
);
  logic [NUM_LINES-1:0] syncA;
  logic [NUM_LINES-1:0] syncB;
  logic [NUM_CORES-1:0][GROUPS-1:0][31:0] enReg;
  logic [NUM_CORES-1:0][GROUPS-1:0][31:0] statusW;
  logic [NUM_CORES-1:0] anyPend;
  logic [31:0] readWord;
  logic unusedStrobe;

  assign unusedStrobe = ^strobe.enWrite;

  // two-flop synchronizer on every line
  always_ff @(posedge clk) begin
    if (!rstN) begin
      syncA <= '0;
      syncB <= '0;
    end else begin
      syncA <= irqIn;
      syncB <= syncA;
    end
  end

  // per-core enable banks
  always_ff @(posedge clk) begin
    if (!rstN) begin
      enReg <= '0;
    end else begin
      for (int c = 0; c < NUM_CORES; c++) begin
        for (int g = 0; g < GROUPS; g++) begin
          if (strobe.enWrite[c * MaxGroups + g]) enReg[c][g] <= busWdata;
        end
      end
    end
  end

  // live masked status and per-core request
  genvar gc, gg;
  generate
    for (gc = 0; gc < NUM_CORES; gc++) begin : g_core
      for (gg = 0; gg < GROUPS; gg++) begin : g_grp
        assign statusW[gc][gg] = syncB[gg*32 +: 32] & enReg[gc][gg];
      end
      assign anyPend[gc] = |statusW[gc];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) cpuIrq <= '0;
    else       cpuIrq <= anyPend;
  end

  // read mux
  always_comb begin
    readWord = '0;
    for (int c = 0; c < NUM_CORES; c++) begin
      for (int g = 0; g < GROUPS; g++) begin
        if (strobe.rdMapped && (c == int'(strobe.rdCore)) &&
            (g == int'(strobe.rdGroup))) begin
          readWord = strobe.rdEnable ? enReg[c][g] : statusW[c][g];
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)                busRdata <= '0;
    else if (strobe.rdStrobe) busRdata <= readWord;
  end
endmodule

// File: rtl/irq_aggr.sv
module irq_aggr
  import irq_aggr_pkg::*;
#(
  parameter int NUM_LINES = 64,
  parameter int NUM_CORES = 2,
  parameter int ADDR_W    = 6
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_LINES-1:0] irqIn,
  input  logic                 busValid,
  input  logic                 busWrite,
  input  logic [ADDR_W-1:0]    busAddr,
  input  logic [31:0]          busWdata,
  output logic [31:0]          busRdata,
  output logic [NUM_CORES-1:0] cpuIrq
);
  localparam int Groups = NUM_LINES / 32;

  aggrStrobe_t strobe;

  irq_aggr_ctrl #(
    .NUM_CORES(NUM_CORES),
    .GROUPS   (Groups),
    .ADDR_W   (ADDR_W)
  ) u_ctrl (
    .busValid(busValid),
    .busWrite(busWrite),
    .busAddr (busAddr),
    .strobe  (strobe)
  );

  irq_aggr_datapath #(
    .NUM_LINES(NUM_LINES),
    .NUM_CORES(NUM_CORES),
    .GROUPS   (Groups)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .irqIn   (irqIn),
    .busWdata(busWdata),
    .strobe  (strobe),
    .busRdata(busRdata),
    .cpuIrq  (cpuIrq)
  );
endmodule

// File: rtl/irq_aggr_checker.sv
module irq_aggr_checker
  import irq_aggr_pkg::*;
#(
  parameter int NUM_LINES = 64,
  parameter int NUM_CORES = 2,
  parameter int ADDR_W    = 6
) (
  input logic                 clk,
  input logic                 rstN,
  input logic [NUM_LINES-1:0] irqIn,
  input logic                 busValid,
  input logic                 busWrite,
  input logic [ADDR_W-1:0]    busAddr,
  input logic [31:0]          busRdata,
  input logic [NUM_CORES-1:0] cpuIrq,
  input aggrStrobe_t          strobe
);
  localparam int Groups = NUM_LINES / 32;

  a_r1_reset_quiet: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (cpuIrq == '0 && busRdata == '0));

  a_r6_irq_needs_line: assert property (@(posedge clk) disable iff (!rstN)
    (cpuIrq != '0) |-> ($past(irqIn, 3) != '0));

  a_r4_status_write_inert: assert property (@(posedge clk) disable iff (!rstN)
    (busValid && busWrite && (int'(busAddr[4:2]) < Groups)) |-> (strobe.enWrite == '0));

  a_r2_one_enable_word: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strobe.enWrite));

  a_r8_unmapped_zero: assert property (@(posedge clk) disable iff (!rstN)
    (busValid && !busWrite && (int'(busAddr[4:2]) >= 2 * Groups)) |=> (busRdata == '0));

  a_r9_write_holds_rdata: assert property (@(posedge clk) disable iff (!rstN)
    (busValid && busWrite) |=> $stable(busRdata));
endmodule

bind irq_aggr irq_aggr_checker #(
  .NUM_LINES(NUM_LINES),
  .NUM_CORES(NUM_CORES),
  .ADDR_W   (ADDR_W)
) chk (
  .clk     (clk),
  .rstN    (rstN),
  .irqIn   (irqIn),
  .busValid(busValid),
  .busWrite(busWrite),
  .busAddr (busAddr),
  .busRdata(busRdata),
  .cpuIrq  (cpuIrq),
  .strobe  (strobe)
);

// File: tb/irq_aggr_test.sv
module irq_aggr_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [63:0] irqIn = '0;
  logic        busValid = 1'b0;
  logic        busWrite = 1'b0;
  logic [5:0]  busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic [1:0]  cpuIrq;

  int total = 0;
  int bad = 0;
  logic [31:0] expQ[$];
  string       tagQ[$];

  always #2 clk = ~clk;

  irq_aggr uut (
    .clk(clk), .rstN(rstN), .irqIn(irqIn),
    .busValid(busValid), .busWrite(busWrite), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .cpuIrq(cpuIrq)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic waitNeg(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic busWr(logic [5:0] addr, logic [31:0] data);
    @(negedge clk);
    busValid = 1'b1; busWrite = 1'b1; busAddr = addr; busWdata = data;
    @(negedge clk);
    busValid = 1'b0; busWrite = 1'b0;
  endtask

  task automatic busRd(logic [5:0] addr, logic [31:0] exp, string tag);
    @(negedge clk);
    busValid = 1'b1; busWrite = 1'b0; busAddr = addr;
    expQ.push_back(exp);
    tagQ.push_back(tag);
    @(negedge clk);
    busValid = 1'b0;
  endtask

  // monitor: read data is due at the falling edge after the accepting edge
  initial begin
    forever begin
      @(posedge clk);
      if (rstN && busValid && !busWrite) begin
        @(negedge clk);
        if (expQ.size() == 0) begin
          chk("scoreboard underflow", 32'h1, 32'h0);
        end else begin
          chk(tagQ.pop_front(), busRdata, expQ.pop_front());
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    waitNeg(5);
    rstN = 1'b1;
    waitNeg(1);
    chk("R1 cpuIrq after reset", {30'd0, cpuIrq}, 32'd0);
    chk("R1 rdata after reset", busRdata, 32'd0);
    busRd(6'h08, 32'h0, "R1 core0 enable g1");
    busRd(6'h0C, 32'h0, "R1 core0 enable g0");
    busRd(6'h28, 32'h0, "R1 core1 enable g1");
    busRd(6'h2C, 32'h0, "R1 core1 enable g0");

    busWr(6'h0C, 32'hA5A5_0F0F);
    busWr(6'h08, 32'h8000_0001);
    busRd(6'h0C, 32'hA5A5_0F0F, "R2 core0 enable g0 readback");
    busRd(6'h09, 32'h8000_0001, "R5 low address bits ignored, g1 at lower offset");
    busRd(6'h2C, 32'h0, "R7 core1 enable untouched");

    @(negedge clk);
    irqIn = 64'h0000_0001_0000_0F00;
    waitNeg(2);
    chk("R6 cpuIrq not yet at edge 2", {30'd0, cpuIrq}, 32'd0);
    waitNeg(1);
    chk("R6 cpuIrq at edge 3", {30'd0, cpuIrq}, 32'd1);
    busRd(6'h04, 32'h0000_0F00, "R3 core0 status g0");
    busRd(6'h00, 32'h0000_0001, "R5 core0 status g1 at offset 0");
    busRd(6'h24, 32'h0, "R7 core1 status g0");
    busRd(6'h20, 32'h0, "R7 core1 status g1");

    @(negedge clk);
    irqIn = '0;
    waitNeg(2);
    chk("R6 cpuIrq held until edge 3", {30'd0, cpuIrq}, 32'd1);
    waitNeg(1);
    chk("R6 cpuIrq drops at edge 3", {30'd0, cpuIrq}, 32'd0);
    busRd(6'h04, 32'h0, "R3 status clears with line");

    @(negedge clk);
    irqIn = 64'h0000_0100_0000_0000;
    waitNeg(4);
    chk("R7 masked line keeps both low", {30'd0, cpuIrq}, 32'd0);
    busWr(6'h28, 32'h0000_0100);
    chk("R6 enable write not yet visible", {30'd0, cpuIrq}, 32'd0);
    waitNeg(1);
    chk("R7 only core1 raised", {30'd0, cpuIrq}, 32'd2);
    busRd(6'h20, 32'h0000_0100, "R3 core1 status g1");

    busWr(6'h20, 32'hFFFF_FFFF);
    busWr(6'h24, 32'hFFFF_FFFF);
    busRd(6'h28, 32'h0000_0100, "R4 core1 enable g1 after status write");
    busRd(6'h2C, 32'h0, "R4 core1 enable g0 after status write");
    busRd(6'h24, 32'h0, "R4 core1 status g0 unchanged");
    chk("R4 cpuIrq unchanged", {30'd0, cpuIrq}, 32'd2);

    busRd(6'h28, 32'h0000_0100, "R8 setup read");
    busRd(6'h14, 32'h0, "R8 unmapped word 5");
    busRd(6'h3C, 32'h0, "R8 unmapped word 7 core1");

    busRd(6'h0C, 32'hA5A5_0F0F, "R9 setup read");
    busWr(6'h2C, 32'h0000_0001);
    waitNeg(2);
    chk("R9 rdata held over write and idle", busRdata, 32'hA5A5_0F0F);
    busRd(6'h2C, 32'h0000_0001, "R2 core1 enable g0 readback");

    waitNeg(3);
    chk("scoreboard drained", expQ.size(), 32'd0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule